// File: doc/BRIEF.md
# Erasable Byte-Wide Program Memory Emulator

This block is a synthesizable model of a 2048 x 8 memory whose bits can only be cleared by programming and set back to one by a bulk erase. It is meant to sit inside a test system in place of a real part. Programmer logic and bus logic can then be checked against it cycle by cycle. Three control inputs select one of six operating modes: an active-low chip select that doubles as the program strobe, an active-low output gate, and a high-programming-voltage flag. The data bus is split into a driven value and an enable, so the surrounding logic can build a tri-state pad or a mux from them.

Programming follows the one-way rule. A legal strobe pulse replaces the addressed byte with the bitwise AND of the stored byte and the input byte. The width of each strobe pulse is measured in clock cycles, scaled from milliseconds by a parameter. Pulses that are too short, too long, or cut off by a mode change write nothing and set a sticky error flag. After reset the outputs stay floated until the address has changed once. A one-cycle erase request sweeps the whole array to ones, one location per cycle, while a busy flag is high.

Top module: `eprom_emu`

## Requirements
- R1: A one-cycle `erase_req` while idle raises `erase_busy` from the next cycle, for exactly 2^ADDR_W cycles. During that time `dout_en` stays 0. Afterwards every byte reads 0xFF.
- R2: In read mode (`ce_pgm`=0, `oe`=0, `vpp_hi`=0) and with the output unlocked, `dout_en` is 1 and `dout` shows the byte stored at `addr`, one clock after `addr` is sampled.
- R3: While `ce_pgm`=1, `dout_en` is 0 whatever `oe` and `vpp_hi` are.
- R4: While `oe`=1 with `vpp_hi`=0, `dout_en` is 0.
- R5: With `vpp_hi`=1 and `oe`=1, a `ce_pgm` pulse that stays high for N sampled cycles, with MIN_CYC <= N <= MAX_CYC, stores the old byte AND `din` at `addr` when the pulse falls. MIN_CYC = 45*CYC_PER_MS and MAX_CYC = 55*CYC_PER_MS, i.e. 180 and 220 by default.
- R6: Programming never turns a 0 bit into 1. Programming 0x5A over a stored 0xA5 leaves 0x00.
- R7: In verify mode (`vpp_hi`=1, `ce_pgm`=0, `oe`=0) the stored byte is driven, just as in read mode.
- R8: In inhibit mode (`vpp_hi`=1, `oe`=1, `ce_pgm`=0) `dout_en` is 0 and the array is not written.
- R9: A pulse with N < MIN_CYC writes nothing and sets `pulse_err`.
- R10: A `ce_pgm` held high for more than MAX_CYC sampled cycles sets `pulse_err` on cycle MAX_CYC+1 and writes nothing, even after it falls.
- R11: After reset `dout_en` stays 0 in read mode until `addr` differs from its value on the previous clock at least once.
- R12: `pulse_err` is 0 after reset and stays 1 until the next reset. Pulses of exactly MIN_CYC and exactly MAX_CYC cycles are legal.
- R13: A pulse that is still high when `vpp_hi` or `oe` drops writes nothing and sets `pulse_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| ce_pgm | input | 1 | Active-low select; high-going pulse is the program strobe |
| oe | input | 1 | Active-low output gate |
| vpp_hi | input | 1 | Programming voltage present |
| din | input | DATA_W | Byte to program |
| erase_req | input | 1 | One-cycle bulk erase request |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Bus drive enable |
| erase_busy | output | 1 | Erase sweep in progress |
| pulse_err | output | 1 | Sticky illegal-pulse flag |

## Verification
The properties assume that every input is synchronous to `clk`. They also assume that `addr` and `din` are held steady from the rising edge of a program strobe until the cycle after it falls, and that no erase is requested during a strobe. The stimulus changes inputs only on falling clock edges. It sets address and data one cycle before raising the strobe and keeps them until two cycles after it drops. It issues erase requests only while the control pins sit in a read or idle combination.

// File: rtl/eprom_emu_pkg.sv
package eprom_emu_pkg;
  typedef enum logic [2:0] {
    M_STANDBY, M_READ, M_OFF, M_PROG, M_VERIFY, M_INHIBIT
  } mode_e;

  function automatic mode_e decode_mode(logic ce, logic oe, logic vpp);
    mode_e m;
    if (ce)       m = (vpp && oe) ? M_PROG : M_STANDBY;
    else if (!oe) m = vpp ? M_VERIFY : M_READ;
    else          m = vpp ? M_INHIBIT : M_OFF;
    return m;
  endfunction
endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_emu_pkg::*;
(
  input  logic  ce,
  input  logic  oe,
  input  logic  vpp,
  output mode_e mode,
  output logic  drive,
  output logic  prog_window
);
  always_comb begin
    mode        = decode_mode(ce, oe, vpp);
    drive       = (mode == M_READ) || (mode == M_VERIFY);
    prog_window = vpp && oe;
  end
endmodule

// File: rtl/eprom_pulse_timer.sv
module eprom_pulse_timer #(
  parameter int MIN_CYC = 180,
  parameter int MAX_CYC = 220
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic window,
  output logic wr_stb,
  output logic err
);
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_CYC);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_CYC);

  logic          strobe_q, armed_q, err_q;
  logic          armed_n, err_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          rise;

  always_comb begin
    rise    = strobe && !strobe_q;
    armed_n = armed_q;
    err_n   = err_q;
    cnt_n   = cnt_q;
    wr_stb  = 1'b0;
    if (armed_q) begin
      if (!window) begin
        armed_n = 1'b0;
        err_n   = 1'b1;
      end else if (strobe) begin
        if (cnt_q == MAX_C) begin
          armed_n = 1'b0;
          err_n   = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else begin
        armed_n = 1'b0;
        if (cnt_q >= MIN_C) wr_stb = 1'b1;
        else                err_n  = 1'b1;
      end
    end else if (window && rise) begin
      armed_n = 1'b1;
      cnt_n   = CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      armed_q  <= 1'b0;
      err_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      strobe_q <= strobe;
      armed_q  <= armed_n;
      err_q    <= err_n;
      cnt_q    <= cnt_n;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_req,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q, ptr_n;
  logic          busy_q, busy_n;
  logic          prog_en;

  always_comb begin
    ptr_n   = ptr_q;
    busy_n  = busy_q;
    prog_en = wr_en && !busy_q;
    if (busy_q) begin
      ptr_n = ptr_q + 1'b1;
      if (ptr_q == '1) busy_n = 1'b0;
    end else if (erase_req) begin
      busy_n = 1'b1;
      ptr_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_n;
      busy_q <= busy_n;
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q)       mem[ptr_q]   <= '1;
    else if (prog_en) mem[wr_addr] <= mem[wr_addr] & wr_data;
    rd_data <= mem[rd_addr];
  end

  assign busy = busy_q;
endmodule

// File: rtl/eprom_emu.sv
module eprom_emu #(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int CYC_PER_MS   = 4,
  parameter int PULSE_MIN_MS = 45,
  parameter int PULSE_MAX_MS = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_pgm,
  input  logic              oe,
  input  logic              vpp_hi,
  input  logic [DATA_W-1:0] din,
  input  logic              erase_req,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              erase_busy,
  output logic              pulse_err
);
  import eprom_emu_pkg::*;

  localparam int MIN_CYC = PULSE_MIN_MS * CYC_PER_MS;
  localparam int MAX_CYC = PULSE_MAX_MS * CYC_PER_MS;

  mode_e             mode;
  logic              drive, window, wr_stb;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] addr_q;
  logic              seen_q, unlocked_q, unlocked_n;

  eprom_mode_decode u_dec (
    .ce(ce_pgm), .oe(oe), .vpp(vpp_hi),
    .mode(mode), .drive(drive), .prog_window(window)
  );

  eprom_pulse_timer #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .strobe(ce_pgm), .window(window),
    .wr_stb(wr_stb), .err(pulse_err)
  );

  eprom_array #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .erase_req(erase_req),
    .rd_addr(addr), .wr_en(wr_stb), .wr_addr(addr), .wr_data(din),
    .rd_data(rd_data), .busy(erase_busy)
  );

  always_comb begin
    unlocked_n = unlocked_q || (seen_q && (addr != addr_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      seen_q     <= 1'b0;
      unlocked_q <= 1'b0;
    end else begin
      addr_q     <= addr;
      seen_q     <= 1'b1;
      unlocked_q <= unlocked_n;
    end
  end

  always_comb begin
    dout_en = drive && unlocked_q && !erase_busy && (mode != M_PROG);
    dout    = dout_en ? rd_data : '0;
  end
endmodule

// File: rtl/eprom_emu_chk.sv
module eprom_emu_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_pgm,
  input logic oe,
  input logic vpp_hi,
  input logic erase_req,
  input logic erase_busy,
  input logic pulse_err,
  input logic dout_en
);
  p_standby_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_pgm |-> !dout_en);
  p_gate_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !vpp_hi) |-> !dout_en);
  p_inhibit_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && vpp_hi && !ce_pgm) |-> !dout_en);
  p_busy_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> !dout_en);
  p_erase_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !erase_busy) |=> erase_busy);
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_err |=> pulse_err);
endmodule

bind eprom_emu eprom_emu_chk u_chk (.*);

// File: tb/eprom_emu_test.sv
module eprom_emu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic       ce_pgm = 1'b0, oe = 1'b0, vpp_hi = 1'b0, erase_req = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_en, erase_busy, pulse_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { bit en; logic [7:0] d; string req; } item_t;
  item_t q[$];
  event mon_ev;

  always #4 clk = ~clk;

  eprom_emu uut (.*);

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard driver side: push expected bus state, monitor compares
  task automatic expect_bus(bit en, logic [7:0] d, string req);
    item_t it;
    it.en = en; it.d = d; it.req = req;
    q.push_back(it);
    -> mon_ev;
    #1;
  endtask

  always begin
    @(mon_ev);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (dout_en !== it.en || (it.en && dout !== it.d)) begin
        errors++;
        $display("FAIL %s actual=%b/%h expected=%b/%h", it.req, dout_en, dout, it.en, it.d);
      end
    end
  end

  task automatic ctl(logic c, logic o, logic v);
    ce_pgm = c; oe = o; vpp_hi = v;
  endtask

  task automatic prog(logic [10:0] a, logic [7:0] d, int width);
    ctl(1'b0, 1'b1, 1'b1); addr = a; din = d;
    step(1);
    ce_pgm = 1'b1;
    step(width);
    ce_pgm = 1'b0;
    step(2);
  endtask

  task automatic read_at(logic [10:0] a, logic v, bit en, logic [7:0] d, string req);
    ctl(1'b0, 1'b0, v); addr = a;
    step(3);
    expect_bus(en, d, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
  endtask

  task automatic erase_all(string req);
    int n = 0;
    erase_req = 1'b1; step(1); erase_req = 1'b0;
    while (erase_busy && n < 5000) begin
      if (n == 100) expect_bus(1'b0, 8'h00, req);
      n++; step(1);
    end
    check_val(req, n, 2048);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    // R12 reset state
    check_val("R12", pulse_err, 0);
    check_val("R1", erase_busy, 0);
    expect_bus(1'b0, 8'h00, "R11");
    erase_all("R1");
    // R11 still locked: address never changed
    ctl(1'b0, 1'b0, 1'b0); step(2);
    expect_bus(1'b0, 8'h00, "R11");
    read_at(11'd5, 1'b0, 1'b1, 8'hFF, "R11");
    read_at(11'd2047, 1'b0, 1'b1, 8'hFF, "R1");
    // R5 legal program, R7 verify
    prog(11'd5, 8'hA5, 200);
    read_at(11'd5, 1'b1, 1'b1, 8'hA5, "R7");
    // R6 only clears; R12 minimum width legal
    prog(11'd5, 8'h5A, 180);
    read_at(11'd5, 1'b0, 1'b1, 8'h00, "R6");
    prog(11'd6, 8'hF0, 220);
    read_at(11'd6, 1'b0, 1'b1, 8'hF0, "R12");
    check_val("R12", pulse_err, 0);
    read_at(11'd6, 1'b0, 1'b1, 8'hF0, "R2");
    // R8 inhibit
    ctl(1'b0, 1'b1, 1'b1); addr = 11'd7; din = 8'h00; step(3);
    expect_bus(1'b0, 8'h00, "R8");
    read_at(11'd7, 1'b0, 1'b1, 8'hFF, "R8");
    // R4, R3
    ctl(1'b0, 1'b1, 1'b0); step(2);
    expect_bus(1'b0, 8'h00, "R4");
    ctl(1'b1, 1'b0, 1'b0); step(2);
    expect_bus(1'b0, 8'h00, "R3");
    ctl(1'b1, 1'b0, 1'b1); step(2);
    expect_bus(1'b0, 8'h00, "R3");
    // R9 short pulse
    prog(11'd8, 8'h00, 179);
    check_val("R9", pulse_err, 1);
    read_at(11'd8, 1'b0, 1'b1, 8'hFF, "R9");
    step(20);
    check_val("R12", pulse_err, 1);
    do_reset();
    check_val("R12", pulse_err, 0);
    // R10 held too long
    ctl(1'b0, 1'b1, 1'b1); addr = 11'd9; din = 8'h00;
    step(1);
    ce_pgm = 1'b1;
    step(220);
    check_val("R10", pulse_err, 0);
    step(1);
    check_val("R10", pulse_err, 1);
    step(40);
    ce_pgm = 1'b0; step(2);
    read_at(11'd9, 1'b0, 1'b1, 8'hFF, "R10");
    do_reset();
    // R13 aborted pulse
    ctl(1'b0, 1'b1, 1'b1); addr = 11'd10; din = 8'h00;
    step(1);
    ce_pgm = 1'b1; step(200);
    oe = 1'b0; step(2);
    ce_pgm = 1'b0; step(2);
    check_val("R13", pulse_err, 1);
    read_at(11'd10, 1'b0, 1'b1, 8'hFF, "R13");
    read_at(11'd6, 1'b0, 1'b1, 8'hF0, "R2");
    // R1 erase restores ones, floats while busy
    erase_all("R1");
    read_at(11'd5, 1'b0, 1'b1, 8'hFF, "R1");
    read_at(11'd6, 1'b0, 1'b1, 8'hFF, "R1");
    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule